// File: doc/BRIEF.md
# Dual-Slot Rule Operation Executor

This block is the action stage of a pipelined packet-filter rule engine. Every cycle in which an instruction executes, it receives an 18-bit operation field that holds two independent 9-bit slots. It also receives the two single-bit flags and the two 32-bit result words produced by the engine's function units. Each slot picks one action: a rate-limit check, a save into a register, a jump, or nothing. Each slot also carries a condition or source code and a register or destination code.

The block owns the state these actions touch. That state is four rate-limit counters, four single-bit registers, four base registers and eight 32-bit general registers. A limit action whose condition holds decrements its counter. If that counter is already exhausted, the action instead asks for the current packet to be dropped. Jump slots are only resolved here. Their taken flags and destination codes go to a separate program sequencer. When a save changes a base register, a pulse and a mask are raised so that the sequencer can refetch packet operands. Counters are refilled through a simple load port.

Top module: `rule_op_exec`

## Requirements
- R1: Slot 0 is op_field[17:9] and slot 1 is op_field[8:0]. In each slot, bits [8:7] select the action: 00 limit, 01 save, 10 jump, 11 none. Bits [6:4] hold the condition or source code and bits [3:0] hold the register or destination code. The two slots act independently.
- R2: Limit and jump conditions are selected by code: 0 flag0, 1 flag1, 2 OR, 3 NOR, 4 AND, 5 NAND, 6 XOR, 7 always true.
- R3: A limit slot with a true condition and register code 0..3 decrements counter L0..L3 by one when that counter is nonzero. Two slots that hit the same counter in one cycle decrement it only once.
- R4: A limit slot with a true condition whose selected counter is zero raises drop_req in that same cycle. The counter stays at zero.
- R5: Save source codes are: 0 flag0, 1 flag1, 2 flag0 OR flag1, 3 flag0 AND flag1, 4 word0, 5 word1. A one-bit source is zero-extended into wide registers. A single-bit register keeps bit 0 of a word source.
- R6: Save destination codes map as follows: 0..3 go to single-bit registers T0..T3, 4..7 to base registers B0..B3, and 8..15 to general registers G0..G7. A written value appears on the outputs one cycle after the instruction.
- R7: When both slots save to the same register in one cycle, the value from slot 1 is kept.
- R8: A slot marked none, a save with source code 6 or 7, a limit with register code 4..15, and any cycle with op_valid low all leave every register and counter unchanged and raise no drop.
- R9: A jump slot raises its jump_take bit in the same cycle exactly when its condition is true. It presents its low 4 bits on its jump_dst output and changes no register.
- R10: A save into a base register pulses base_chg for one cycle, together with the new register value, and base_chg_mask marks which base registers changed.
- R11: A counter load writes lim_load_val into counter lim_load_sel and takes priority over a decrement of that counter in the same cycle.
- R12: Synchronous active-low reset clears all counters and registers and deasserts base_chg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An instruction executes this cycle |
| op_field | input | 18 | Two 9-bit operation slots |
| flag0 | input | 1 | Flag from function 0 |
| flag1 | input | 1 | Flag from function 1 |
| word0 | input | DATA_W | Result word from function 0 |
| word1 | input | DATA_W | Result word from function 1 |
| lim_load | input | 1 | Load a rate-limit counter |
| lim_load_sel | input | 2 | Counter to load |
| lim_load_val | input | CNT_W | Value to load |
| drop_req | output | 1 | Drop the current packet (combinational) |
| jump_take | output | 2 | Per-slot jump condition true (combinational) |
| jump_dst0 | output | 4 | Destination code of slot 0 |
| jump_dst1 | output | 4 | Destination code of slot 1 |
| lim_cnt | output | 4*CNT_W | Counters L0..L3, L0 in the low bits |
| tbit | output | 4 | Single-bit registers T0..T3 |
| base_regs | output | 4*DATA_W | Base registers B0..B3, B0 in the low bits |
| gpr_regs | output | 8*DATA_W | General registers G0..G7, G0 in the low bits |
| base_chg | output | 1 | A base register changed last cycle |
| base_chg_mask | output | 4 | Which base registers changed |

## Verification
The bench sweeps every condition code against all four flag pairs in both slots. A design with a swapped NOR/NAND or XOR table shows a wrong jump_take bit. It also sweeps every save source into a single-bit, a base and a general register. A design that skips the zero-extension, or takes the wrong bit when truncating, shows a wrong register value. A counter is driven down to zero and then hit again, so a wrapping counter or a missing drop shows up at once. The bench also checks a same-register collision between the slots, two hits on one counter, a load that meets a decrement, and reserved codes. A design that resolved these the other way, or treated a reserved code as live, changes state that must stay fixed.

// File: rtl/rule_op_pkg.sv
// Shared encodings and helpers for the dual-slot rule operation executor.
// Assumes the fixed 9-bit slot layout: action[8:7], code[6:4], reg[3:0].
package rule_op_pkg;

    localparam int SLOT_W   = 9;
    localparam int NUM_SLOT = 2;
    localparam int NUM_LIM  = 4;
    localparam int NUM_TBIT = 4;
    localparam int NUM_BASE = 4;
    localparam int NUM_GPR  = 8;
    localparam int NUM_DST  = NUM_TBIT + NUM_BASE + NUM_GPR;

    typedef enum logic [1:0] {
        ACT_LIMIT = 2'b00,
        ACT_SAVE  = 2'b01,
        ACT_JUMP  = 2'b10,
        ACT_NONE  = 2'b11
    } slot_act_e;

    // Decoded per-slot control, excluding the save data word
    typedef struct packed {
        logic       lim_hit;
        logic [1:0] lim_sel;
        logic       sv_en;
        logic [3:0] sv_dst;
        logic       jmp_take;
        logic [3:0] jmp_dst;
    } slot_ctl_t;

    // Resolve a 3-bit condition code over the two flags
    function automatic logic cond_eval(input logic [2:0] code,
                                       input logic f0, input logic f1);
        logic r;
        case (code)
            3'd0:    r = f0;
            3'd1:    r = f1;
            3'd2:    r = f0 | f1;
            3'd3:    r = ~(f0 | f1);
            3'd4:    r = f0 & f1;
            3'd5:    r = ~(f0 & f1);
            3'd6:    r = f0 ^ f1;
            default: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rule_slot_dec.sv
// One operation slot: decodes the action, evaluates its condition or source,
// and emits write/limit/jump controls. Purely combinational.
// Assumes reserved codes are filtered here so downstream logic sees no-ops.
module rule_slot_dec
    import rule_op_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                valid,
    input  logic [SLOT_W-1:0]   slot,
    input  logic                flag0,
    input  logic                flag1,
    input  logic [DATA_W-1:0]   word0,
    input  logic [DATA_W-1:0]   word1,
    output slot_ctl_t           ctl,
    output logic [DATA_W-1:0]   sv_data
);

    slot_act_e  act;
    logic [2:0] code;
    logic [3:0] regc;
    logic       cond;

    assign act  = slot_act_e'(slot[8:7]);
    assign code = slot[6:4];
    assign regc = slot[3:0];
    assign cond = cond_eval(code, flag0, flag1);

    // Build the control record for this slot
    always_comb begin
        ctl          = '0;
        ctl.lim_sel  = regc[1:0];
        ctl.sv_dst   = regc;
        ctl.jmp_dst  = regc;
        ctl.lim_hit  = valid && (act == ACT_LIMIT) && cond && (regc < 4'd4);
        ctl.sv_en    = valid && (act == ACT_SAVE) && (code < 3'd6);
        ctl.jmp_take = valid && (act == ACT_JUMP) && cond;
    end

    // Select the save source, zero-extending single-bit sources
    always_comb begin
        case (code)
            3'd0:    sv_data = DATA_W'(flag0);
            3'd1:    sv_data = DATA_W'(flag1);
            3'd2:    sv_data = DATA_W'(flag0 | flag1);
            3'd3:    sv_data = DATA_W'(flag0 & flag1);
            3'd4:    sv_data = word0;
            3'd5:    sv_data = word1;
            default: sv_data = '0;
        endcase
    end

endmodule

// File: rtl/rule_rate_bank.sv
// Rate-limit counters with a load port. A hit on a nonzero counter
// decrements it once; a hit on a zero counter raises a drop request.
// Assumes at most one decrement per counter per cycle; load has priority.
module rule_rate_bank
    import rule_op_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SLOT-1:0]       hit,
    input  logic [NUM_SLOT-1:0][1:0]  sel,
    input  logic                      load,
    input  logic [1:0]                load_sel,
    input  logic [CNT_W-1:0]          load_val,
    output logic [NUM_LIM*CNT_W-1:0]  cnt_flat,
    output logic                      drop
);

    logic [NUM_LIM-1:0] zero_hit;

    for (genvar i = 0; i < NUM_LIM; i++) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        logic             any_hit;

        // Gather hits from all slots that address this counter
        always_comb begin
            any_hit = 1'b0;
            for (int s = 0; s < NUM_SLOT; s++) begin
                if (hit[s] && (sel[s] == 2'(i))) any_hit = 1'b1;
            end
        end

        // Counter update: reset, load, or decrement-if-nonzero
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (load && (load_sel == 2'(i))) begin
                cnt_q <= load_val;
            end else if (any_hit && (cnt_q != '0)) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        assign zero_hit[i]                   = any_hit && (cnt_q == '0);
        assign cnt_flat[i*CNT_W +: CNT_W]    = cnt_q;
    end

    assign drop = |zero_hit;

endmodule

// File: rtl/rule_save_file.sv
// Save-target registers: single-bit T regs, base regs and general regs,
// written by two ports where port 1 wins a same-target collision.
// Also registers a per-base-register change mask for one cycle.
module rule_save_file
    import rule_op_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_SLOT-1:0]              wen,
    input  logic [NUM_SLOT-1:0][3:0]         wdst,
    input  logic [NUM_SLOT-1:0][DATA_W-1:0]  wdata,
    output logic [NUM_TBIT-1:0]              tbit,
    output logic [NUM_BASE*DATA_W-1:0]       base_flat,
    output logic [NUM_GPR*DATA_W-1:0]        gpr_flat,
    output logic [NUM_BASE-1:0]              base_mask
);

    logic [NUM_DST-1:0]              dst_we;
    logic [NUM_DST-1:0][DATA_W-1:0]  dst_wd;

    // Per-target write enable and data, later slot overriding earlier
    always_comb begin
        dst_we = '0;
        dst_wd = '0;
        for (int d = 0; d < NUM_DST; d++) begin
            for (int s = 0; s < NUM_SLOT; s++) begin
                if (wen[s] && (wdst[s] == 4'(d))) begin
                    dst_we[d] = 1'b1;
                    dst_wd[d] = wdata[s];
                end
            end
        end
    end

    for (genvar t = 0; t < NUM_TBIT; t++) begin : g_tbit
        // Single-bit register keeps bit 0 of the source
        always_ff @(posedge clk) begin
            if (!rst_n)         tbit[t] <= 1'b0;
            else if (dst_we[t]) tbit[t] <= dst_wd[t][0];
        end
    end

    for (genvar b = 0; b < NUM_BASE; b++) begin : g_base
        logic [DATA_W-1:0] q;
        // Base register storage
        always_ff @(posedge clk) begin
            if (!rst_n)                  q <= '0;
            else if (dst_we[NUM_TBIT+b]) q <= dst_wd[NUM_TBIT+b];
        end
        // Change flag for this base register, one cycle wide
        always_ff @(posedge clk) begin
            if (!rst_n) base_mask[b] <= 1'b0;
            else        base_mask[b] <= dst_we[NUM_TBIT+b];
        end
        assign base_flat[b*DATA_W +: DATA_W] = q;
    end

    for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
        logic [DATA_W-1:0] q;
        // General register storage
        always_ff @(posedge clk) begin
            if (!rst_n)                           q <= '0;
            else if (dst_we[NUM_TBIT+NUM_BASE+g]) q <= dst_wd[NUM_TBIT+NUM_BASE+g];
        end
        assign gpr_flat[g*DATA_W +: DATA_W] = q;
    end

endmodule

// File: rtl/rule_op_exec.sv
// Top of the dual-slot rule operation executor. Splits the operation field
// into two slots, decodes each, and drives the rate-limit bank and the
// save-target registers. Jumps are resolved only; flow control is external.
module rule_op_exec
    import rule_op_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        op_valid,
    input  logic [2*SLOT_W-1:0]         op_field,
    input  logic                        flag0,
    input  logic                        flag1,
    input  logic [DATA_W-1:0]           word0,
    input  logic [DATA_W-1:0]           word1,
    input  logic                        lim_load,
    input  logic [1:0]                  lim_load_sel,
    input  logic [CNT_W-1:0]            lim_load_val,
    output logic                        drop_req,
    output logic [NUM_SLOT-1:0]         jump_take,
    output logic [3:0]                  jump_dst0,
    output logic [3:0]                  jump_dst1,
    output logic [NUM_LIM*CNT_W-1:0]    lim_cnt,
    output logic [NUM_TBIT-1:0]         tbit,
    output logic [NUM_BASE*DATA_W-1:0]  base_regs,
    output logic [NUM_GPR*DATA_W-1:0]   gpr_regs,
    output logic                        base_chg,
    output logic [NUM_BASE-1:0]         base_chg_mask
);

    slot_ctl_t                          ctl   [NUM_SLOT];
    logic [NUM_SLOT-1:0][DATA_W-1:0]    sv_data;
    logic [NUM_SLOT-1:0]                lim_hit;
    logic [NUM_SLOT-1:0][1:0]           lim_sel;
    logic [NUM_SLOT-1:0]                sv_en;
    logic [NUM_SLOT-1:0][3:0]           sv_dst;

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        rule_slot_dec #(.DATA_W(DATA_W)) u_dec (
            .valid   (op_valid),
            .slot    (op_field[SLOT_W*(NUM_SLOT-s)-1 -: SLOT_W]),
            .flag0   (flag0),
            .flag1   (flag1),
            .word0   (word0),
            .word1   (word1),
            .ctl     (ctl[s]),
            .sv_data (sv_data[s])
        );
        assign lim_hit[s]   = ctl[s].lim_hit;
        assign lim_sel[s]   = ctl[s].lim_sel;
        assign sv_en[s]     = ctl[s].sv_en;
        assign sv_dst[s]    = ctl[s].sv_dst;
        assign jump_take[s] = ctl[s].jmp_take;
    end

    assign jump_dst0 = ctl[0].jmp_dst;
    assign jump_dst1 = ctl[1].jmp_dst;

    rule_rate_bank #(.CNT_W(CNT_W)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (lim_hit),
        .sel      (lim_sel),
        .load     (lim_load),
        .load_sel (lim_load_sel),
        .load_val (lim_load_val),
        .cnt_flat (lim_cnt),
        .drop     (drop_req)
    );

    rule_save_file #(.DATA_W(DATA_W)) u_save (
        .clk       (clk),
        .rst_n     (rst_n),
        .wen       (sv_en),
        .wdst      (sv_dst),
        .wdata     (sv_data),
        .tbit      (tbit),
        .base_flat (base_regs),
        .gpr_flat  (gpr_regs),
        .base_mask (base_chg_mask)
    );

    assign base_chg = |base_chg_mask;

endmodule

// File: rtl/rule_op_exec_chk.sv
// Checker for rule_op_exec: port-level temporal properties on counters,
// drops, jumps and base-change reporting. Attached by bind below.
module rule_op_exec_chk
    import rule_op_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        op_valid,
    input  logic                        lim_load,
    input  logic [1:0]                  lim_load_sel,
    input  logic [CNT_W-1:0]            lim_load_val,
    input  logic                        drop_req,
    input  logic [NUM_SLOT-1:0]         jump_take,
    input  logic [NUM_LIM*CNT_W-1:0]    lim_cnt,
    input  logic [NUM_BASE-1:0]         base_chg_mask
);

    logic [CNT_W-1:0] cnt_a [NUM_LIM];
    for (genvar i = 0; i < NUM_LIM; i++) begin : g_unpack
        assign cnt_a[i] = lim_cnt[i*CNT_W +: CNT_W];

        AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            !lim_load |=> (cnt_a[i] == $past(cnt_a[i])) ||
                          (cnt_a[i] == CNT_W'($past(cnt_a[i]) - 1'b1))); // R3

        AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (!lim_load && cnt_a[i] == '0) |=> cnt_a[i] == '0); // R4
    end

    AST_DROP_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        drop_req |-> op_valid); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !lim_load) |=> $stable(lim_cnt)); // R8

    AST_JUMP_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_take != '0) |-> op_valid); // R9

    AST_BASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> base_chg_mask == '0); // R10

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        lim_load |=> cnt_a[$past(lim_load_sel)] == $past(lim_load_val)); // R11

endmodule

bind rule_op_exec rule_op_exec_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .lim_load      (lim_load),
    .lim_load_sel  (lim_load_sel),
    .lim_load_val  (lim_load_val),
    .drop_req      (drop_req),
    .jump_take     (jump_take),
    .lim_cnt       (lim_cnt),
    .base_chg_mask (base_chg_mask)
);

// File: tb/rule_op_exec_tb.sv
// Self-checking bench: sweeps condition and source codes, drives counters
// through zero, and covers collisions, loads, reserved codes and base pulses.
module rule_op_exec_tb_top;

    localparam int DW = 32;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [17:0]   op_field = '0;
    logic          flag0 = 1'b0, flag1 = 1'b0;
    logic [DW-1:0] word0 = '0, word1 = '0;
    logic          lim_load = 1'b0;
    logic [1:0]    lim_load_sel = '0;
    logic [CW-1:0] lim_load_val = '0;
    logic          drop_req;
    logic [1:0]    jump_take;
    logic [3:0]    jump_dst0, jump_dst1;
    logic [4*CW-1:0] lim_cnt;
    logic [3:0]    tbit;
    logic [4*DW-1:0] base_regs;
    logic [8*DW-1:0] gpr_regs;
    logic          base_chg;
    logic [3:0]    base_chg_mask;

    int checks = 0;
    int errors = 0;
    logic          s_drop;
    logic [1:0]    s_jump;
    logic [3:0]    s_d0, s_d1;

    always #10 clk = ~clk;

    rule_op_exec #(.DATA_W(DW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_field(op_field),
        .flag0(flag0), .flag1(flag1), .word0(word0), .word1(word1),
        .lim_load(lim_load), .lim_load_sel(lim_load_sel), .lim_load_val(lim_load_val),
        .drop_req(drop_req), .jump_take(jump_take), .jump_dst0(jump_dst0),
        .jump_dst1(jump_dst1), .lim_cnt(lim_cnt), .tbit(tbit),
        .base_regs(base_regs), .gpr_regs(gpr_regs), .base_chg(base_chg),
        .base_chg_mask(base_chg_mask)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] slot(input logic [1:0] a, input logic [2:0] c, input logic [3:0] r);
        return {a, c, r};
    endfunction

    function automatic logic cond_ref(input int c, input logic f0, input logic f1);
        int n = int'(f0) + int'(f1);
        case (c)
            0: return f0;
            1: return f1;
            2: return n >= 1;
            3: return n == 0;
            4: return n == 2;
            5: return n != 2;
            6: return n == 1;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [DW-1:0] src_ref(input int c, input logic f0, input logic f1,
                                              input logic [DW-1:0] w0, input logic [DW-1:0] w1);
        case (c)
            0: return {31'd0, f0};
            1: return {31'd0, f1};
            2: return {31'd0, f0 | f1};
            3: return {31'd0, f0 & f1};
            4: return w0;
            default: return w1;
        endcase
    endfunction

    function automatic logic [CW-1:0] cnt(input int i);
        return lim_cnt[i*CW +: CW];
    endfunction
    function automatic logic [DW-1:0] gpr(input int i);
        return gpr_regs[i*DW +: DW];
    endfunction
    function automatic logic [DW-1:0] base(input int i);
        return base_regs[i*DW +: DW];
    endfunction

    // Apply one instruction for one cycle; capture combinational outputs
    task automatic exec(input logic [17:0] op, input logic f0, input logic f1,
                        input logic [DW-1:0] w0, input logic [DW-1:0] w1);
        @(negedge clk);
        op_valid = 1'b1; op_field = op; flag0 = f0; flag1 = f1; word0 = w0; word1 = w1;
        #2;
        s_drop = drop_req; s_jump = jump_take; s_d0 = jump_dst0; s_d1 = jump_dst1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic load(input logic [1:0] sel, input logic [CW-1:0] val);
        @(negedge clk);
        lim_load = 1'b1; lim_load_sel = sel; lim_load_val = val;
        @(negedge clk);
        lim_load = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] w0, w1, e, hold_g3;
        logic [4*CW-1:0] cnt_hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk("R12 counters", {96'd0, lim_cnt}, '0);
        chk("R12 tbits", {28'd0, tbit}, '0);
        chk("R12 gprs", {224'd0, gpr_regs} == '0, 1);
        chk("R12 bases", {128'd0, base_regs} == '0, 1);
        chk("R12 base_chg", {31'd0, base_chg}, 0);

        // R1 R2 R9: condition sweep via jumps in both slots
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 4; f++) begin
                exec({slot(2'b10, 3'(c), 4'(c + 2)), slot(2'b10, 3'(7 - c), 4'(15 - c))},
                     f[0], f[1], '0, '0);
                chk("R2 slot0 cond", {31'd0, s_jump[0]}, {31'd0, cond_ref(c, f[0], f[1])});
                chk("R1 slot1 cond", {31'd0, s_jump[1]}, {31'd0, cond_ref(7 - c, f[0], f[1])});
                chk("R9 dst0", {28'd0, s_d0}, 32'(c + 2));
                chk("R9 dst1", {28'd0, s_d1}, 32'(15 - c));
                chk("R9 no drop", {31'd0, s_drop}, 0);
            end
        end
        chk("R9 jumps leave regs", {31'd0, (gpr_regs == '0) && (tbit == '0) && (lim_cnt == '0)}, 1);

        // R5 R6: save source sweep into T1/G3, then B2/T2
        for (int c = 0; c < 6; c++) begin
            for (int f = 0; f < 4; f++) begin
                w0 = 32'hA5C3_0F10 ^ 32'(f * 3 + c);
                w1 = 32'h1357_9BD0 + 32'(c * 5 + f);
                e  = src_ref(c, f[0], f[1], w0, w1);
                exec({slot(2'b01, 3'(c), 4'd1), slot(2'b01, 3'(c), 4'd11)}, f[0], f[1], w0, w1);
                chk("R5 T1 bit0", {31'd0, tbit[1]}, {31'd0, e[0]});
                chk("R6 G3 value", gpr(3), e);
                exec({slot(2'b01, 3'(c), 4'd6), slot(2'b01, 3'(c), 4'd2)}, f[0], f[1], w0, w1);
                chk("R6 B2 value", base(2), e);
                chk("R5 T2 bit0", {31'd0, tbit[2]}, {31'd0, e[0]});
                chk("R10 B2 pulse", {28'd0, base_chg_mask}, 32'h4);
            end
        end

        // R8: reserved save sources, no-op slots, reserved limit registers
        hold_g3 = gpr(3);
        exec({slot(2'b01, 3'd6, 4'd11), slot(2'b01, 3'd7, 4'd11)}, 1'b1, 1'b1, '1, '1);
        chk("R8 reserved source", gpr(3), hold_g3);
        load(2'd1, 8'd5);
        cnt_hold = lim_cnt;
        exec({slot(2'b11, 3'd5, 4'd11), slot(2'b11, 3'd2, 4'd1)}, 1'b1, 1'b0, '1, '1);
        chk("R8 none keeps G3", gpr(3), hold_g3);
        chk("R8 none keeps counters", {96'd0, lim_cnt}, {96'd0, cnt_hold});
        chk("R8 none no jump/drop", {30'd0, s_jump, s_drop}, 0);
        exec({slot(2'b00, 3'd7, 4'd5), slot(2'b00, 3'd7, 4'd9)}, 1'b0, 1'b0, '0, '0);
        chk("R8 reserved limit reg", {96'd0, lim_cnt}, {96'd0, cnt_hold});
        chk("R8 reserved limit no drop", {31'd0, s_drop}, 0);

        // R3 R4: drive L2 down to zero, then hit again
        load(2'd2, 8'd3);
        chk("R11 load L2", {24'd0, cnt(2)}, 3);
        exec({slot(2'b11, 3'd0, 4'd0), slot(2'b00, 3'd7, 4'd2)}, 1'b0, 1'b0, '0, '0);
        chk("R3 dec to 2", {24'd0, cnt(2)}, 2);
        exec({slot(2'b00, 3'd0, 4'd2), slot(2'b11, 3'd0, 4'd0)}, 1'b0, 1'b1, '0, '0);
        chk("R3 false cond holds", {24'd0, cnt(2)}, 2);
        exec({slot(2'b00, 3'd4, 4'd2), slot(2'b11, 3'd0, 4'd0)}, 1'b1, 1'b1, '0, '0);
        chk("R3 dec to 1", {24'd0, cnt(2)}, 1);
        exec({slot(2'b00, 3'd6, 4'd2), slot(2'b11, 3'd0, 4'd0)}, 1'b1, 1'b0, '0, '0);
        chk("R3 dec to 0", {24'd0, cnt(2)}, 0);
        chk("R3 no drop while nonzero", {31'd0, s_drop}, 0);
        exec({slot(2'b11, 3'd0, 4'd0), slot(2'b00, 3'd3, 4'd2)}, 1'b0, 1'b0, '0, '0);
        chk("R4 drop at zero", {31'd0, s_drop}, 1);
        chk("R4 stays zero", {24'd0, cnt(2)}, 0);
        chk("R4 L1 untouched", {24'd0, cnt(1)}, 5);

        // R11: load and decrement on the same counter in one cycle
        @(negedge clk);
        lim_load = 1'b1; lim_load_sel = 2'd2; lim_load_val = 8'd9;
        op_valid = 1'b1; op_field = {slot(2'b00, 3'd7, 4'd2), slot(2'b11, 3'd0, 4'd0)};
        @(negedge clk);
        lim_load = 1'b0; op_valid = 1'b0;
        chk("R11 load beats decrement", {24'd0, cnt(2)}, 9);

        // R3: both slots hit L2 in one cycle, single decrement
        exec({slot(2'b00, 3'd7, 4'd2), slot(2'b00, 3'd2, 4'd2)}, 1'b1, 1'b0, '0, '0);
        chk("R3 double hit once", {24'd0, cnt(2)}, 8);

        // R7: both slots save to G5 and to T0
        exec({slot(2'b01, 3'd4, 4'd13), slot(2'b01, 3'd5, 4'd13)}, 1'b0, 1'b0,
             32'h0BAD_F00D, 32'hCAFE_0002);
        chk("R7 slot1 wins G5", gpr(5), 32'hCAFE_0002);
        exec({slot(2'b01, 3'd0, 4'd0), slot(2'b01, 3'd1, 4'd0)}, 1'b1, 1'b0, '0, '0);
        chk("R7 slot1 wins T0", {31'd0, tbit[0]}, 0);

        // R10: base change pulse and mask
        exec({slot(2'b01, 3'd4, 4'd5), slot(2'b11, 3'd0, 4'd0)}, 1'b0, 1'b0, 32'h0000_1234, '0);
        chk("R10 pulse", {31'd0, base_chg}, 1);
        chk("R10 mask B1", {28'd0, base_chg_mask}, 32'h2);
        chk("R10 B1 value", base(1), 32'h0000_1234);
        @(negedge clk);
        chk("R10 pulse ends", {27'd0, base_chg, base_chg_mask}, 0);
        exec({slot(2'b01, 3'd4, 4'd4), slot(2'b01, 3'd5, 4'd7)}, 1'b0, 1'b0, 32'h11, 32'h77);
        chk("R10 mask B0 B3", {28'd0, base_chg_mask}, 32'h9);
        exec({slot(2'b01, 3'd4, 4'd9), slot(2'b11, 3'd0, 4'd0)}, 1'b0, 1'b0, 32'h55, '0);
        chk("R10 no pulse for G1", {31'd0, base_chg}, 0);
        chk("R6 G1 value", gpr(1), 32'h55);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule